// File: doc/BRIEF.md
# Chip Select and Wait-State Controller

This block sits between a bus master and external memories or peripherals. For every bus cycle it compares the 24-bit address against four programmable chip-select windows. It drives the active-low select of the window that wins, or no select at all when the access falls into the catch-all default region. It then stretches the cycle by the number of wait states that the winning window's control register asks for. One wait mode is open-ended: the cycle continues for as long as an external active-low wait line is held low.

Software fills in the windows through a small indexed register port. The start addresses go first, then the masks, then the control words. Each window compares only the address bits that its mask leaves clear. Window 2 has a second personality. Until its mode bit is set, it covers a hard-wired region of the address map instead of its programmable one. The master raises a one-cycle request while the controller is idle, and the controller raises a one-cycle completion flag in the last state of the cycle. The selected window's bus-width bit is reported next to the selects.

Top module: `cs_wait_ctrl`

## Requirements
- R1: After reset all selects are high and `bus_done` is low. All windows are disabled and every wait field and width bit is zero, so an access takes the default region with 2 waits and `bus_wide` = 0.
- R2: A request accepted at clock edge E gives one setup state, then W wait states, then one final state in which `bus_done` is high. The done state therefore follows edge E+W+1. The 3-bit wait code maps as follows: 011→W=0, 001→1, 000→2, 100→3, 101→4, 110→8.
- R3: Code 010 gives one wait state. At the end of each wait state `wait_n` is sampled: low adds another wait state, high moves to the final state. Holding `wait_n` low for L wait-state samples gives W = L+1.
- R4: For every fixed code (all codes except 010), `wait_n` has no effect on the cycle length.
- R5: Window k matches when `((addr ^ start_k) & ~mask_k) == 0` and its enable bit is set.
- R6: When several windows match, the lowest-numbered window drives its select.
- R7: A disabled window never matches. An access that matches no window asserts no select and takes its wait code (bits 2:0) and width (bit 3) from the default register at index 12.
- R8: Bit 6 of window 2's control word selects its mode. When the bit is 0, window 2 covers 0x000FE0–0x000FFF and 0x003000–0xFF7FFF. When it is 1, window 2 uses its start and mask registers.
- R9: Code 111 gives W = 0 and sets a sticky error flag, readable as bit 0 of index 13. Only reset clears the flag.
- R10: Register indices are: start k at k, mask k at 4+k, control k at 8+k (bits 2:0 wait code, bit 3 width, bit 4 enable, bit 6 mode), default at 12, error at 13. A read shows the indexed register on `reg_rdata` one clock after `reg_addr` is set.
- R11: A request or an address change while a cycle is in progress is ignored. The cycle length and the select are unchanged.
- R12: From the setup state through the done state exactly one select, or none for the default region, is low and stays constant. `bus_wide` gives the width bit of the region that was selected. All selects go high after the done state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index for write and read |
| reg_wdata | input | 24 | Register write data |
| reg_rdata | output | 24 | Registered read data for `reg_addr` |
| bus_req | input | 1 | Cycle request, taken only while idle |
| bus_addr | input | 24 | Cycle address, sampled with the request |
| wait_n | input | 1 | Active-low external wait |
| cs_n | output | 4 | Active-low chip selects, one per window |
| bus_wide | output | 1 | Width bit of the selected region |
| bus_done | output | 1 | High in the final state of a cycle |

## Verification
The assertions check on every cycle that at most one select is low, that the select pattern holds steady until completion, and that completion lasts one state and returns the selects high. They also check that a low `wait_n` in the open-ended mode holds off completion, that requests arriving mid-cycle cause no restart, that default accesses drive no select, and that the error flag never clears itself. Only the bench scenarios can show the exact wait count for each code, the mask comparison and the window priority. The same holds for the enable fall-through, the two personalities of window 2 and the register readback.

// File: rtl/cs_wait_pkg.sv
package cs_wait_pkg;

  localparam int CNT_W = 4;

  // area control word fields as stored
  typedef struct packed {
    logic       mode;   // area with fixed region: 1 = programmable
    logic       en;
    logic       wide;
    logic [2:0] code;
  } ctl_t;

  typedef struct packed {
    logic       wide;
    logic [2:0] code;
  } dflt_t;

  typedef struct packed {
    logic [CNT_W-1:0] waits;
    logic             pin_ext;
    logic             bad;
  } wait_plan_t;

  function automatic wait_plan_t decode_wait(input logic [2:0] code);
    wait_plan_t p;
    p = '{waits: '0, pin_ext: 1'b0, bad: 1'b0};
    case (code)
      3'b000: p.waits = CNT_W'(2);
      3'b001: p.waits = CNT_W'(1);
      3'b010: begin p.waits = CNT_W'(1); p.pin_ext = 1'b1; end
      3'b011: p.waits = '0;
      3'b100: p.waits = CNT_W'(3);
      3'b101: p.waits = CNT_W'(4);
      3'b110: p.waits = CNT_W'(8);
      default: p.bad = 1'b1;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/cs_area_match.sv
module cs_area_match #(
  parameter int ADDR_W = 24,
  parameter logic [ADDR_W-1:0] FIXA_LO = ADDR_W'('h000FE0),
  parameter logic [ADDR_W-1:0] FIXA_HI = ADDR_W'('h000FFF),
  parameter logic [ADDR_W-1:0] FIXB_LO = ADDR_W'('h003000),
  parameter logic [ADDR_W-1:0] FIXB_HI = ADDR_W'('hFF7FFF)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] start,
  input  logic [ADDR_W-1:0] mask,
  input  logic              enable,
  input  logic              use_fixed,
  output logic              hit
);
  logic prog_hit, fixed_hit;

  assign prog_hit  = ((addr ^ start) & ~mask) == '0;
  assign fixed_hit = ((addr >= FIXA_LO) && (addr <= FIXA_HI)) ||
                     ((addr >= FIXB_LO) && (addr <= FIXB_HI));
  assign hit = enable && (use_fixed ? fixed_hit : prog_hit);
endmodule

// File: rtl/cs_regs.sv
module cs_regs
  import cs_wait_pkg::*;
#(
  parameter int N_AREA = 4,
  parameter int ADDR_W = 24,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [ADDR_W-1:0] wdata,
  input  logic              err_set,
  output logic [ADDR_W-1:0] rdata,
  output logic [ADDR_W-1:0] start_q [N_AREA],
  output logic [ADDR_W-1:0] mask_q  [N_AREA],
  output ctl_t              ctl_q   [N_AREA],
  output dflt_t             dflt_q
);
  localparam int MASK_BASE = N_AREA;
  localparam int CTL_BASE  = 2 * N_AREA;
  localparam int DFLT_IDX  = 3 * N_AREA;
  localparam int ERR_IDX   = 3 * N_AREA + 1;

  logic              err_q;
  logic [ADDR_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < N_AREA; k++) begin
      if (idx == IDX_W'(k))             rd_mux = start_q[k];
      if (idx == IDX_W'(MASK_BASE + k)) rd_mux = mask_q[k];
      if (idx == IDX_W'(CTL_BASE + k))
        rd_mux = ADDR_W'({ctl_q[k].mode, 1'b0, ctl_q[k].en, ctl_q[k].wide, ctl_q[k].code});
    end
    if (idx == IDX_W'(DFLT_IDX)) rd_mux = ADDR_W'({dflt_q.wide, dflt_q.code});
    if (idx == IDX_W'(ERR_IDX))  rd_mux = ADDR_W'(err_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < N_AREA; k++) begin
        start_q[k] <= '0;
        mask_q[k]  <= '0;
        ctl_q[k]   <= '0;
      end
      dflt_q <= '0;
      err_q  <= 1'b0;
      rdata  <= '0;
    end else begin
      if (we) begin
        for (int k = 0; k < N_AREA; k++) begin
          if (idx == IDX_W'(k))             start_q[k] <= wdata;
          if (idx == IDX_W'(MASK_BASE + k)) mask_q[k]  <= wdata;
          if (idx == IDX_W'(CTL_BASE + k))
            ctl_q[k] <= '{mode: wdata[6], en: wdata[4], wide: wdata[3], code: wdata[2:0]};
        end
        if (idx == IDX_W'(DFLT_IDX)) dflt_q <= '{wide: wdata[3], code: wdata[2:0]};
      end
      if (err_set) err_q <= 1'b1;
      rdata <= rd_mux;
    end
  end

  // error flag never clears outside reset
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst) err_q |=> err_q);

endmodule

// File: rtl/cs_wait_seq.sv
module cs_wait_seq
  import cs_wait_pkg::*;
#(
  parameter int N_AREA = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [N_AREA-1:0] sel,
  input  wait_plan_t        plan,
  input  logic              wide,
  input  logic              wait_n,
  output logic              busy,
  output logic [N_AREA-1:0] cs_n,
  output logic              wide_q,
  output logic              done
);
  logic [CNT_W-1:0] cnt;
  logic             ext_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      cs_n   <= '1;
      wide_q <= 1'b0;
      cnt    <= '0;
      ext_q  <= 1'b0;
    end else if (!busy) begin
      if (req) begin
        busy   <= 1'b1;
        cs_n   <= ~sel;
        wide_q <= wide;
        cnt    <= plan.waits;
        ext_q  <= plan.pin_ext;
      end
    end else if (done) begin
      busy <= 1'b0;
      done <= 1'b0;
      cs_n <= '1;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end else if (!(ext_q && !wait_n)) begin
      done <= 1'b1;
    end
  end

  assert_cs_onehot_R12: assert property (@(posedge clk) disable iff (rst) $onehot0(~cs_n));
  assert_cs_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> $stable(cs_n));
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && (&cs_n) && !busy));
  assert_pin_extends_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && !done && ext_q && cnt == '0 && !wait_n) |=> !done);
  assert_no_restart_R11: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> busy);

endmodule

// File: rtl/cs_wait_ctrl.sv
module cs_wait_ctrl
  import cs_wait_pkg::*;
#(
  parameter int N_AREA     = 4,
  parameter int ADDR_W     = 24,
  parameter int FIXED_AREA = 2,
  localparam int IDX_W     = $clog2(3 * N_AREA + 2),
  localparam int PICK_W    = (N_AREA > 1) ? $clog2(N_AREA) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [IDX_W-1:0]  reg_addr,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  input  logic              bus_req,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              wait_n,
  output logic [N_AREA-1:0] cs_n,
  output logic              bus_wide,
  output logic              bus_done
);
  logic [ADDR_W-1:0] start_q [N_AREA];
  logic [ADDR_W-1:0] mask_q  [N_AREA];
  ctl_t              ctl_q   [N_AREA];
  dflt_t             dflt_q;

  logic [N_AREA-1:0] hit, sel;
  logic [PICK_W-1:0] pick;
  logic              any_hit, sel_wide, busy, err_set;
  wait_plan_t        plan;

  cs_regs #(.N_AREA(N_AREA), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .idx(reg_addr), .wdata(reg_wdata),
    .err_set(err_set), .rdata(reg_rdata),
    .start_q(start_q), .mask_q(mask_q), .ctl_q(ctl_q), .dflt_q(dflt_q)
  );

  for (genvar g = 0; g < N_AREA; g++) begin : g_area
    cs_area_match #(.ADDR_W(ADDR_W)) u_match (
      .addr(bus_addr), .start(start_q[g]), .mask(mask_q[g]),
      .enable(ctl_q[g].en),
      .use_fixed((g == FIXED_AREA) && !ctl_q[g].mode),
      .hit(hit[g])
    );
  end

  // lowest index wins
  always_comb begin
    pick = '0;
    for (int i = N_AREA - 1; i >= 0; i--)
      if (hit[i]) pick = PICK_W'(i);
    any_hit = |hit;
    sel = '0;
    if (any_hit) sel[pick] = 1'b1;
    plan     = any_hit ? decode_wait(ctl_q[pick].code) : decode_wait(dflt_q.code);
    sel_wide = any_hit ? ctl_q[pick].wide : dflt_q.wide;
  end

  assign err_set = bus_req && !busy && plan.bad;

  cs_wait_seq #(.N_AREA(N_AREA)) u_seq (
    .clk(clk), .rst(rst), .req(bus_req), .sel(sel), .plan(plan),
    .wide(sel_wide), .wait_n(wait_n), .busy(busy),
    .cs_n(cs_n), .wide_q(bus_wide), .done(bus_done)
  );

  assert_default_no_cs_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !busy && !any_hit) |=> (&cs_n));
  assert_prio_low_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !busy && hit[0]) |=> !cs_n[0]);

endmodule

// File: tb/tb_cs_wait_ctrl.sv
module tb_cs_wait_ctrl;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [23:0] reg_wdata = '0;
  logic [23:0] reg_rdata;
  logic        bus_req = 1'b0;
  logic [23:0] bus_addr = '0;
  logic        wait_n = 1'b1;
  logic [3:0]  cs_n;
  logic        bus_wide, bus_done;

  int checks = 0;
  int fails  = 0;

  always #(CLK_P / 2) clk = ~clk;

  cs_wait_ctrl dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_req(bus_req),
    .bus_addr(bus_addr), .wait_n(wait_n), .cs_n(cs_n),
    .bus_wide(bus_wide), .bus_done(bus_done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int idx, input int val);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'(idx); reg_wdata = 24'(val);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int idx, output int val);
    @(negedge clk);
    reg_addr = 4'(idx);
    @(negedge clk);
    val = int'(reg_rdata);
  endtask

  // run one cycle; low_len>0 holds wait_n low for that many samples
  task automatic access(input logic [23:0] a, input int low_len, input bit hold,
                        input logic [23:0] alt, output int waits,
                        output logic [3:0] cs, output bit wide, output bit stable);
    @(negedge clk);
    bus_addr = a; bus_req = 1'b1; wait_n = (low_len > 0) ? 1'b0 : 1'b1;
    @(negedge clk);
    if (hold) bus_addr = alt; else bus_req = 1'b0;
    cs = cs_n; wide = bus_wide; stable = 1'b1; waits = -1;
    for (int k = 0; k < 40; k++) begin
      if (cs_n !== cs) stable = 1'b0;
      if (low_len > 0 && k >= low_len + 1) wait_n = 1'b1;
      if (bus_done) begin waits = k - 1; break; end
      @(negedge clk);
    end
    bus_req = 1'b0; wait_n = 1'b1;
    @(negedge clk);
    chk(cs_n == 4'hF, "R12 selects released", int'(cs_n), 15);
  endtask

  task automatic expect_acc(input logic [23:0] a, input int low_len, input int ew,
                            input logic [3:0] ecs, input bit ewide, input string tag);
    int w; logic [3:0] c; bit wd, st;
    access(a, low_len, 1'b0, '0, w, c, wd, st);
    chk(w == ew, {tag, " waits"}, w, ew);
    chk(c == ecs, {tag, " select"}, int'(c), int'(ecs));
    chk(wd == ewide, {tag, " width R12"}, int'(wd), int'(ewide));
    chk(st, {tag, " select steady R12"}, int'(st), 1);
  endtask

  function automatic int fixed_waits(input int code);
    case (code)
      0: return 2; 1: return 1; 3: return 0;
      4: return 3; 5: return 4; 6: return 8;
      default: return 0;
    endcase
  endfunction

  task automatic t_reset;
    int v;
    chk(cs_n == 4'hF, "R1 reset selects", int'(cs_n), 15);
    chk(bus_done == 1'b0, "R1 reset done", int'(bus_done), 0);
    expect_acc(24'h123456, 0, 2, 4'hF, 1'b0, "R1 reset default");
    rd(13, v);
    chk(v == 0, "R9 error clear after reset", v, 0);
  endtask

  task automatic t_regs;
    int v;
    wr(0, 24'h100000); wr(4, 24'h0FFFFF); wr(8, 24'h10);
    rd(0, v); chk(v == 24'h100000, "R10 start readback", v, 24'h100000);
    rd(4, v); chk(v == 24'h0FFFFF, "R10 mask readback", v, 24'h0FFFFF);
    rd(8, v); chk(v == 24'h10, "R10 control readback", v, 24'h10);
  endtask

  task automatic t_codes;
    int codes[6] = '{0, 1, 3, 4, 5, 6};
    foreach (codes[i]) begin
      wr(8, 24'h10 | codes[i]);
      expect_acc(24'h1ABCDE, 0, fixed_waits(codes[i]), 4'b1110, 1'b0, "R2 fixed code");
      expect_acc(24'h1ABCDE, 4, fixed_waits(codes[i]), 4'b1110, 1'b0, "R4 wait pin ignored");
    end
  endtask

  task automatic t_pin;
    wr(8, 24'h12);
    expect_acc(24'h100000, 0, 1, 4'b1110, 1'b0, "R3 pin high");
    expect_acc(24'h100000, 5, 6, 4'b1110, 1'b0, "R3 pin held low");
  endtask

  task automatic t_bad;
    int v;
    wr(8, 24'h17);
    expect_acc(24'h100000, 0, 0, 4'b1110, 1'b0, "R9 reserved code");
    rd(13, v); chk(v == 1, "R9 error set", v, 1);
    wr(8, 24'h10);
    expect_acc(24'h100000, 0, 2, 4'b1110, 1'b0, "R9 valid code after");
    rd(13, v); chk(v == 1, "R9 error sticky", v, 1);
  endtask

  task automatic t_mask;
    wr(1, 24'h200000); wr(5, 24'h00FFFF); wr(9, 24'h1B);
    expect_acc(24'h20ABCD, 0, 0, 4'b1101, 1'b1, "R5 masked match");
    expect_acc(24'h21ABCD, 0, 2, 4'hF, 1'b0, "R5 compared bit differs");
  endtask

  task automatic t_prio;
    wr(1, 24'h100000); wr(5, 24'h0FFFFF);
    expect_acc(24'h150000, 0, 2, 4'b1110, 1'b0, "R6 lowest wins");
    wr(8, 24'h00);
    expect_acc(24'h150000, 0, 0, 4'b1101, 1'b1, "R7 disabled falls through");
    wr(9, 24'h0B); wr(12, 24'h0C);
    expect_acc(24'h150000, 0, 3, 4'hF, 1'b1, "R7 default register");
  endtask

  task automatic t_fixed;
    wr(10, 24'h13);
    expect_acc(24'h000FE0, 0, 0, 4'b1011, 1'b0, "R8 fixed low start");
    expect_acc(24'h000FFF, 0, 0, 4'b1011, 1'b0, "R8 fixed low end");
    expect_acc(24'h000FDF, 0, 3, 4'hF, 1'b1, "R8 below fixed");
    expect_acc(24'h001000, 0, 3, 4'hF, 1'b1, "R8 gap");
    expect_acc(24'h003000, 0, 0, 4'b1011, 1'b0, "R8 fixed high start");
    expect_acc(24'hFF7FFF, 0, 0, 4'b1011, 1'b0, "R8 fixed high end");
    expect_acc(24'hFF8000, 0, 3, 4'hF, 1'b1, "R8 above fixed");
    wr(2, 24'hF00000); wr(6, 24'h00FFFF); wr(10, 24'h53);
    expect_acc(24'hF0AAAA, 0, 0, 4'b1011, 1'b0, "R8 programmable");
    expect_acc(24'h003000, 0, 3, 4'hF, 1'b1, "R8 fixed region dropped");
  endtask

  task automatic t_busy;
    int w; logic [3:0] c; bit wd, st;
    wr(10, 24'h56);
    access(24'hF00001, 0, 1'b1, 24'h003000, w, c, wd, st);
    chk(w == 8, "R11 no restart waits", w, 8);
    chk(c == 4'b1011, "R11 select", int'(c), 11);
    chk(st, "R11 select unchanged", int'(st), 1);
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_codes();
    t_pin();
    t_bad();
    t_mask();
    t_prio();
    t_fixed();
    t_busy();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule